// File: doc/BRIEF.md
# Display Command Byte Parser

This block sits behind a serial-peripheral slave that has already assembled whole bytes. Each byte arrives with a select level. When the select level is high, the byte is pixel data and goes straight to the panel address generator. When it is low, the byte belongs to the command stream. A command is one opcode byte followed by a fixed number of argument bytes. That number depends on the opcode and ranges from zero to eight. The parser counts the argument bytes and applies the command once the last one arrives.

Only three commands change any output. The column window command and the row window command emit a load pulse together with start and end bounds, reduced modulo the panel width (64 byte columns) or height (80 rows). The remap command latches its single argument. Electrical and brightness commands are recognised, and their arguments are consumed and thrown away. An opcode outside the known set produces a one-cycle error pulse, and the parser then waits for a new opcode.

Every output is registered and reflects the byte accepted at the previous clock edge.

Top module: `disp_cmd_parser`

## Requirements
- R1: A byte accepted with `data_sel` = 1 appears on `data_byte` with `data_valid` = 1 in the following cycle. It produces no error and no window load, and it leaves the command state untouched.
- R2: In command mode the first byte is the opcode. The next N bytes are its arguments, where N comes from the opcode. After the N-th argument the next command byte is again treated as an opcode.
- R3: Opcode 0x15 takes two arguments. One cycle after the second argument, `win_col_load` pulses, `col_start` = first argument mod 64 and `col_end` = second argument mod 64.
- R4: Opcode 0x75 takes two arguments. One cycle after the second argument, `win_row_load` pulses, `row_start` = first argument mod 80 and `row_end` = second argument mod 80.
- R5: Opcode 0xA0 takes one argument, which is latched onto `remap_byte` in the following cycle.
- R6: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF take one argument. That argument changes no output.
- R7: Opcode 0xB8 takes eight arguments. None of them changes any output.
- R8: Opcodes 0x84, 0x85, 0x86, 0xA4, 0xA5, 0xA6, 0xA7, 0xAE, 0xAF and 0xE3 take no argument and complete on the opcode byte itself, with no error and no output change.
- R9: Opcode 0xFF completes on its own byte with no effect and no error.
- R10: Any other opcode makes `err_pulse` high for exactly the following cycle, and the next command byte is treated as an opcode.
- R11: Data-mode bytes received in the middle of a command keep the partial argument count. The command resumes when command bytes return.
- R12: After reset: `col_start` = 0, `col_end` = 63, `row_start` = 0, `row_end` = 79, `remap_byte` = 0, all pulses low, and the parser expects an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A whole byte is presented this cycle |
| byte_in | input | 8 | Received byte |
| data_sel | input | 1 | 1 = pixel data, 0 = command stream |
| data_valid | output | 1 | Pulse: forwarded pixel byte valid |
| data_byte | output | 8 | Forwarded pixel byte |
| win_col_load | output | 1 | Pulse: new column window |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| win_row_load | output | 1 | Pulse: new row window |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| remap_byte | output | 8 | Latched remap setting |
| err_pulse | output | 1 | Pulse: unrecognised opcode |

## Verification
The bench sweeps all 256 opcodes, supplies each with exactly the argument count its own table predicts, and then sends an unknown probe opcode. A parser that miscounts arguments either swallows the probe as an argument, so no error appears, or treats a trailing argument as an opcode and raises a spurious error. Every byte value is passed through both window commands. This catches the row bound that must wrap modulo 80 rather than by truncating bits. Data bytes are interleaved inside a column command and inside the eight-argument command, which catches a parser that restarts or advances its count on pixel traffic.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

  localparam int NARGS_W = 4;

  typedef enum logic [2:0] {
    K_COLWIN,
    K_ROWWIN,
    K_REMAP,
    K_DISCARD,
    K_SWALLOW,
    K_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e            kind;
    logic [NARGS_W-1:0]  nargs;
  } op_info_t;

  localparam logic [7:0] OP_COLWIN = 8'h15;
  localparam logic [7:0] OP_ROWWIN = 8'h75;
  localparam logic [7:0] OP_REMAP  = 8'hA0;
  localparam logic [7:0] OP_GREY   = 8'hB8;
  localparam logic [7:0] OP_SINK   = 8'hFF;

  // Opcode -> behaviour class and number of argument bytes.
  function automatic op_info_t classify(input logic [7:0] op);
    op_info_t r;
    unique case (op)
      OP_COLWIN: r = '{kind: K_COLWIN, nargs: 4'd2};
      OP_ROWWIN: r = '{kind: K_ROWWIN, nargs: 4'd2};
      OP_REMAP:  r = '{kind: K_REMAP,  nargs: 4'd1};
      OP_GREY:   r = '{kind: K_DISCARD, nargs: 4'd8};
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                 r = '{kind: K_DISCARD, nargs: 4'd1};
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3:
                 r = '{kind: K_DISCARD, nargs: 4'd0};
      OP_SINK:   r = '{kind: K_SWALLOW, nargs: 4'd0};
      default:   r = '{kind: K_BAD,     nargs: 4'd0};
    endcase
    return r;
  endfunction

  // Reduce a byte into [0, dim).
  function automatic logic [7:0] wrap_to(input logic [7:0] v, input int unsigned dim);
    int unsigned t;
    t = 32'(v) % dim;
    return t[7:0];
  endfunction

endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
  import disp_cmd_pkg::*;
(
  input  logic [7:0]          opcode,
  output op_kind_e            kind,
  output logic [NARGS_W-1:0]  nargs
);

  op_info_t info;

  always_comb begin
    info  = classify(opcode);
    kind  = info.kind;
    nargs = info.nargs;
  end

  // R10: an unknown opcode never asks for arguments
  always_comb begin
    if (kind == K_BAD) begin
      a_r10_bad_no_args: assert (nargs == '0);
    end
  end

endmodule

// File: rtl/dcp_collector.sv
module dcp_collector
  import disp_cmd_pkg::*;
#(
  parameter int MAX_ARGS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_stb,
  input  logic [7:0]  byte_in,
  output logic        exec_stb,
  output op_kind_e    exec_kind,
  output logic [7:0]  arg0,
  output logic [7:0]  arg1,
  output logic        bad_stb
);

  localparam int CNT_W = $clog2(MAX_ARGS + 1);

  logic              pend_q;
  logic [7:0]        op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        slot_q [MAX_ARGS];
  logic [7:0]        view   [MAX_ARGS];

  logic [7:0]          cur_op;
  op_kind_e            cur_kind;
  logic [NARGS_W-1:0]  cur_nargs;

  logic first_byte;
  logic arg_byte;
  logic last_arg;
  logic open_cmd;

  assign cur_op = pend_q ? op_q : byte_in;

  dcp_decode u_dec (
    .opcode (cur_op),
    .kind   (cur_kind),
    .nargs  (cur_nargs)
  );

  assign first_byte = cmd_stb && !pend_q;
  assign arg_byte   = cmd_stb && pend_q;
  assign last_arg   = arg_byte && ((int'(cnt_q) + 1) == int'(cur_nargs));
  assign open_cmd   = first_byte && (cur_kind != K_BAD) && (cur_nargs != '0);

  assign bad_stb    = first_byte && (cur_kind == K_BAD);
  assign exec_stb   = last_arg ||
                      (first_byte && (cur_kind != K_BAD) && (cur_nargs == '0));
  assign exec_kind  = cur_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= '0;
      cnt_q  <= '0;
    end else if (open_cmd) begin
      pend_q <= 1'b1;
      op_q   <= byte_in;
      cnt_q  <= '0;
    end else if (arg_byte) begin
      if (last_arg) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_slot
    logic hit;
    assign hit     = arg_byte && (cnt_q == CNT_W'(g));
    assign view[g] = hit ? byte_in : slot_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= byte_in;
    end

    // R11: pixel traffic leaves stored arguments alone
    a_r11_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb |=> $stable(slot_q[g]));
  end

  assign arg0 = view[0];
  assign arg1 = view[1];

  // R2: the table never asks for more slots than exist
  always_comb begin
    a_r2_table_fits: assert (int'(cur_nargs) <= MAX_ARGS);
  end

  // R2: a pending command always has an argument still to come
  a_r2_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (int'(cnt_q) < int'(cur_nargs)));

  // R2: completing a command returns to opcode expectation
  a_r2_exec_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> (!pend_q && cnt_q == '0));

  // R10: an unknown opcode leaves the parser idle
  a_r10_bad_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stb |=> !pend_q);

  // R11: no progress or loss of the partial command without command bytes
  a_r11_progress_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> ($stable(pend_q) && $stable(cnt_q) && $stable(op_q)));

endmodule

// File: rtl/dcp_apply.sv
module dcp_apply
  import disp_cmd_pkg::*;
#(
  parameter int COL_DIM = 64,
  parameter int ROW_DIM = 80,
  localparam int COL_W  = $clog2(COL_DIM),
  localparam int ROW_W  = $clog2(ROW_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_stb,
  input  op_kind_e          exec_kind,
  input  logic [7:0]        arg0,
  input  logic [7:0]        arg1,
  input  logic              bad_stb,
  input  logic              data_stb,
  input  logic [7:0]        byte_in,
  output logic              data_valid,
  output logic [7:0]        data_byte,
  output logic              win_col_load,
  output logic [COL_W-1:0]  col_start,
  output logic [COL_W-1:0]  col_end,
  output logic              win_row_load,
  output logic [ROW_W-1:0]  row_start,
  output logic [ROW_W-1:0]  row_end,
  output logic [7:0]        remap_byte,
  output logic              err_pulse
);

  logic do_col, do_row, do_remap;

  assign do_col   = exec_stb && (exec_kind == K_COLWIN);
  assign do_row   = exec_stb && (exec_kind == K_ROWWIN);
  assign do_remap = exec_stb && (exec_kind == K_REMAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_valid   <= 1'b0;
      data_byte    <= '0;
      win_col_load <= 1'b0;
      win_row_load <= 1'b0;
      err_pulse    <= 1'b0;
      col_start    <= '0;
      col_end      <= COL_W'(COL_DIM - 1);
      row_start    <= '0;
      row_end      <= ROW_W'(ROW_DIM - 1);
      remap_byte   <= '0;
    end else begin
      data_valid   <= data_stb;
      win_col_load <= do_col;
      win_row_load <= do_row;
      err_pulse    <= bad_stb;
      if (data_stb) data_byte <= byte_in;
      if (do_col) begin
        col_start <= COL_W'(wrap_to(arg0, COL_DIM));
        col_end   <= COL_W'(wrap_to(arg1, COL_DIM));
      end
      if (do_row) begin
        row_start <= ROW_W'(wrap_to(arg0, ROW_DIM));
        row_end   <= ROW_W'(wrap_to(arg1, ROW_DIM));
      end
      if (do_remap) remap_byte <= arg0;
    end
  end

  // R4: row bounds always inside the panel
  a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(row_start) < ROW_DIM) && (int'(row_end) < ROW_DIM));

  // R1: at most one event per accepted byte
  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_valid, win_col_load, win_row_load, err_pulse}));

  // R1: a forwarded byte follows a data-mode byte
  a_r1_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(data_stb));

  // R5: remap changes only when the remap command completes
  a_r5_remap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !do_remap |=> $stable(remap_byte));

  // R3: column bounds move only together with a load pulse
  a_r3_col_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !win_col_load |-> ($stable(col_start) && $stable(col_end)));

endmodule

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
  import disp_cmd_pkg::*;
#(
  parameter int COL_DIM  = 64,
  parameter int ROW_DIM  = 80,
  parameter int MAX_ARGS = 8,
  localparam int COL_W   = $clog2(COL_DIM),
  localparam int ROW_W   = $clog2(ROW_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic              data_sel,
  output logic              data_valid,
  output logic [7:0]        data_byte,
  output logic              win_col_load,
  output logic [COL_W-1:0]  col_start,
  output logic [COL_W-1:0]  col_end,
  output logic              win_row_load,
  output logic [ROW_W-1:0]  row_start,
  output logic [ROW_W-1:0]  row_end,
  output logic [7:0]        remap_byte,
  output logic              err_pulse
);

  logic      cmd_stb, data_stb;
  logic      exec_stb, bad_stb;
  op_kind_e  exec_kind;
  logic [7:0] arg0, arg1;

  assign cmd_stb  = byte_valid && !data_sel;
  assign data_stb = byte_valid &&  data_sel;

  dcp_collector #(.MAX_ARGS(MAX_ARGS)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .byte_in   (byte_in),
    .exec_stb  (exec_stb),
    .exec_kind (exec_kind),
    .arg0      (arg0),
    .arg1      (arg1),
    .bad_stb   (bad_stb)
  );

  dcp_apply #(.COL_DIM(COL_DIM), .ROW_DIM(ROW_DIM)) u_app (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_stb     (exec_stb),
    .exec_kind    (exec_kind),
    .arg0         (arg0),
    .arg1         (arg1),
    .bad_stb      (bad_stb),
    .data_stb     (data_stb),
    .byte_in      (byte_in),
    .data_valid   (data_valid),
    .data_byte    (data_byte),
    .win_col_load (win_col_load),
    .col_start    (col_start),
    .col_end      (col_end),
    .win_row_load (win_row_load),
    .row_start    (row_start),
    .row_end      (row_end),
    .remap_byte   (remap_byte),
    .err_pulse    (err_pulse)
  );

  // R10: errors and completions never coincide
  a_r10_err_excl_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_stb && exec_stb));

endmodule

// File: tb/disp_cmd_parser_bench.sv
module disp_cmd_parser_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic data_sel = 1'b0;
  logic data_valid, win_col_load, win_row_load, err_pulse;
  logic [7:0] data_byte, remap_byte;
  logic [5:0] col_start, col_end;
  logic [6:0] row_start, row_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79, m_remap = 0;

  always #10 clk = ~clk;

  disp_cmd_parser u_disp_cmd_parser (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .data_sel(data_sel), .data_valid(data_valid), .data_byte(data_byte),
    .win_col_load(win_col_load), .col_start(col_start), .col_end(col_end),
    .win_row_load(win_row_load), .row_start(row_start), .row_end(row_end),
    .remap_byte(remap_byte), .err_pulse(err_pulse)
  );

  // Bench's own view of the opcode table: -1 marks an unknown opcode.
  function automatic int need_of(input int op);
    if (op inside {'h15, 'h75}) return 2;
    if (op == 'hB8) return 8;
    if (op inside {'h81, 'hA0, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2, 'hB3,
                   'hBC, 'hBE, 'hBF}) return 1;
    if (op inside {['h84:'h86], ['hA4:'hA7], 'hAE, 'hAF, 'hE3, 'hFF}) return 0;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one byte for one clock edge; returns at the next falling edge.
  task automatic send(input int b, input bit sel);
    byte_in    = 8'(b);
    data_sel   = sel;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic check_state(input string req);
    check({req, " col_start"},  int'(col_start),  m_cs);
    check({req, " col_end"},    int'(col_end),    m_ce);
    check({req, " row_start"},  int'(row_start),  m_rs);
    check({req, " row_end"},    int'(row_end),    m_re);
    check({req, " remap"},      int'(remap_byte), m_remap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 pulses", int'({data_valid, win_col_load, win_row_load, err_pulse}), 0);
    check_state("R12");

    // R1 every data value forwarded, none looks like a command
    for (int v = 0; v < 256; v++) begin
      send(v, 1'b1);
      check("R1 data_valid", int'(data_valid), 1);
      check("R1 data_byte", int'(data_byte), v);
      check("R1 no cmd effect", int'({win_col_load, win_row_load, err_pulse}), 0);
    end
    check_state("R1");

    // R3 column window over all byte values
    for (int a = 0; a < 256; a++) begin
      send('h15, 1'b0);
      send(a, 1'b0);
      check("R3 no early load", int'(win_col_load), 0);
      send(255 - a, 1'b0);
      m_cs = a % 64; m_ce = (255 - a) % 64;
      check("R3 col load", int'(win_col_load), 1);
      check("R3 col_start", int'(col_start), m_cs);
      check("R3 col_end", int'(col_end), m_ce);
    end

    // R4 row window over all byte values, wrap by 80
    for (int a = 0; a < 256; a++) begin
      send('h75, 1'b0);
      send(a, 1'b0);
      send((a * 7 + 3) % 256, 1'b0);
      m_rs = a % 80; m_re = ((a * 7 + 3) % 256) % 80;
      check("R4 row load", int'(win_row_load), 1);
      check("R4 row_start", int'(row_start), m_rs);
      check("R4 row_end", int'(row_end), m_re);
    end

    // R5 remap latch
    for (int v = 0; v < 256; v += 17) begin
      send('hA0, 1'b0);
      send(v, 1'b0);
      m_remap = v;
      check("R5 remap", int'(remap_byte), m_remap);
    end

    // R2 R6 R7 R8 R9 R10: sweep all opcodes, then probe with an unknown opcode
    for (int op = 0; op < 256; op++) begin
      int n;
      n = need_of(op);
      send(op, 1'b0);
      if (n < 0) begin
        check("R10 err on unknown", int'(err_pulse), 1);
      end else begin
        check("R8 R9 no err on known", int'(err_pulse), 0);
        for (int k = 0; k < n; k++) begin
          int f;
          f = (op + k * 37 + 11) % 256;
          send(f, 1'b0);
          check("R6 R7 arg no err", int'(err_pulse), 0);
          if (op == 'h15 && k == 1) begin m_cs = ((op + 11) % 256) % 64; m_ce = f % 64; end
          if (op == 'h75 && k == 1) begin m_rs = ((op + 11) % 256) % 80; m_re = f % 80; end
          if (op == 'hA0) m_remap = f;
        end
        check("R6 R7 R8 R9 col pulse", int'(win_col_load), int'(op == 'h15));
        check("R6 R7 R8 R9 row pulse", int'(win_row_load), int'(op == 'h75));
      end
      check_state("R6 R7 R8 R9 state");
      send('h00, 1'b0);
      check("R2 probe sees opcode", int'(err_pulse), 1);
    end

    // R11 data interleaved inside a column command
    send('h15, 1'b0);
    send(5, 1'b0);
    send('h15, 1'b1);
    check("R11 data passes", int'(data_valid), 1);
    check("R11 no col load on data", int'(win_col_load), 0);
    send(70, 1'b0);
    m_cs = 5; m_ce = 70 % 64;
    check("R11 resumed load", int'(win_col_load), 1);
    check_state("R11 resumed");

    // R11 R7 data interleaved inside the eight-argument command
    send('hB8, 1'b0);
    for (int k = 0; k < 4; k++) send('h00, 1'b0);
    send('h00, 1'b1);
    send('h00, 1'b1);
    for (int k = 0; k < 4; k++) begin
      send('h00, 1'b0);
      check("R11 R7 args no err", int'(err_pulse), 0);
    end
    send('h00, 1'b0);
    check("R11 R7 probe after eight", int'(err_pulse), 1);
    check_state("R7 final");

    // R10 back-to-back unknown opcodes each raise the error
    send('h01, 1'b0);
    check("R10 first", int'(err_pulse), 1);
    send('h02, 1'b0);
    check("R10 second", int'(err_pulse), 1);
    @(negedge clk);
    check("R10 single cycle", int'(err_pulse), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule